// File: doc/BRIEF.md
# Column-parallel SAD block matcher

The matcher scores one 16x16 reference block against every candidate block that fits inside a 24x24 search area. The candidate origin steps one pixel at a time, first left to right and then top to bottom. This gives 81 candidate positions. For each candidate the block is walked one column at a time, left to right. A 16-pixel column is fetched in two beats of eight lanes: the upper eight rows first, then the lower eight.

Each beat reads one pixel from each of eight candidate banks and eight reference banks. The unit forms eight absolute differences and reduces them with a seven-adder binary tree. It adds the tree output into a per-candidate accumulator. When a candidate's last beat leaves the pipeline, its sum of absolute differences goes to a result port at the candidate's raster index. The unit then pulses a completion flag after the 81st result. A downstream agent picks the minimum from the result memory.

Candidates are issued back to back, so a full scan takes 81 x 32 issue cycles plus a three-cycle pipeline. The candidate banks are interleaved by row. A candidate's eight rows therefore fall in eight distinct banks, rotated by the candidate's vertical offset. The datapath undoes that rotation before it pairs each pixel with its reference pixel.

Top module: `sad_column_matcher`

## Requirements
- R1: While reset is held and after it is released, with no start, `res_we` and `done` stay low.
- R2: The value written for candidate origin (cx, cy), with 0 <= cx, cy <= 8, is the sum over 0 <= x, y < 16 of |ref(x,y) - cand(cx+x, cy+y)|, using unsigned 8-bit pixels.
- R3: Candidate index k = 9*cy + cx is written to `res_addr` = k, and the results of a scan appear in increasing k order from 0 to 80.
- R4: Counting the rising edge that samples `start` as edge 0, the result for candidate k is on the write port (`res_we` high) during the cycle after edge 34 + 32k, and `res_we` is low in every other cycle.
- R5: `done` is high for exactly the one cycle that follows the write of candidate 80, and low otherwise.
- R6: A `start` asserted while a scan is in progress has no effect on the writes, their timing or `done`.
- R7: Candidate bank b holds search-area rows r with r mod 8 = b at word (r div 8)*24 + column. Reference bank b holds block rows y with y mod 8 = b at word (y div 8)*16 + column. Read data is returned one cycle after the address is presented.
- R8: In issue cycle c of a scan (c counted from 0 at edge 0), the shared reference address is 16*(c mod 2) + ((c div 2) mod 16), so the upper half of a column is read first, then the lower half.
- R9: The largest possible sum, 65280 (every pair differing by 255), is written without wrap.
- R10: A new `start` given after `done` runs a complete fresh scan on the bank contents then present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a scan when the unit is idle |
| cand_addr | output | 56 | Eight 7-bit word addresses, one per candidate bank, bank b at bits [7b+6:7b] |
| cand_rdata | input | 64 | Eight candidate pixels, bank b at bits [8b+7:8b], valid one cycle after the address |
| ref_addr | output | 5 | Word address shared by all eight reference banks |
| ref_rdata | input | 64 | Eight reference pixels, bank b at bits [8b+7:8b] |
| res_we | output | 1 | Result write strobe |
| res_addr | output | 7 | Result address, the candidate raster index |
| res_wdata | output | 16 | Sum of absolute differences |
| done | output | 1 | One-cycle pulse after the last result |

## Verification
Some properties are checked by assertions on every cycle. Results must come in strict raster order and never on two adjacent cycles. No result may exceed the largest possible sum. `done` must be a lone pulse right behind the write to index 80. Each upper-half reference read must be followed by the matching lower-half read. Other properties can only be shown by the bench scenarios. These are the correctness of each sum, which depends on the bank rotation and the pairing of candidate with reference pixels, the exact write cycles, and the immunity to a mid-scan start. The bench runs random, saturating, exact-match and gradient images, with a restart right after completion.

// File: rtl/sadm_pkg.sv
package sadm_pkg;

  // magnitude of the difference of two unsigned pixels
  function automatic int abs_diff(input int a, input int b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // search-area row served by a bank for a candidate origin row and half
  function automatic int bank_row(input int bank, input int cy, input int half,
                                  input int lanes);
    int off;
    off = ((bank - cy) % lanes + lanes) % lanes;
    return cy + half * lanes + off;
  endfunction

  // word address inside a row-interleaved candidate bank
  function automatic int bank_word(input int bank, input int cy, input int cx,
                                   input int half, input int col,
                                   input int lanes, input int area);
    int r;
    r = bank_row(bank, cy, half, lanes);
    return (r / lanes) * area + cx + col;
  endfunction

endpackage

// File: rtl/sadm_seq.sv
module sadm_seq #(
  parameter int LANES = 8,
  parameter int BLK   = 16,
  parameter int AREA  = 24,
  parameter int CAW   = 7,
  parameter int RAW   = 5,
  parameter int IDXW  = 7,
  parameter int ROTW  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  issue_v,
  output logic [LANES*CAW-1:0]  cand_addr,
  output logic [RAW-1:0]        ref_addr,
  output logic                  s1_valid,
  output logic                  s1_first,
  output logic                  s1_last,
  output logic [IDXW-1:0]       s1_idx,
  output logic [ROTW-1:0]       s1_rot
);
  import sadm_pkg::*;

  localparam int NPOS   = AREA - BLK + 1;
  localparam int HALVES = BLK / LANES;
  localparam int XW     = $clog2(BLK);
  localparam int PW     = $clog2(NPOS);
  localparam int HW     = (HALVES > 1) ? $clog2(HALVES) : 1;

  logic          busy;
  logic [XW-1:0] col;
  logic [HW-1:0] hf;
  logic [PW-1:0] cx, cy;

  logic half_end, col_end, cx_end, cy_end, blk_last;

  assign half_end = (hf == HW'(HALVES - 1));
  assign col_end  = (col == XW'(BLK - 1));
  assign cx_end   = (cx == PW'(NPOS - 1));
  assign cy_end   = (cy == PW'(NPOS - 1));
  assign blk_last = half_end && col_end;
  assign issue_v  = busy;

  // scan counters: half innermost, then column, then cx, then cy
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      col  <= '0;
      hf   <= '0;
      cx   <= '0;
      cy   <= '0;
    end else if (!busy) begin
      col <= '0;
      hf  <= '0;
      cx  <= '0;
      cy  <= '0;
      if (start) busy <= 1'b1;
    end else if (!half_end) begin
      hf <= hf + 1'b1;
    end else begin
      hf <= '0;
      if (!col_end) begin
        col <= col + 1'b1;
      end else begin
        col <= '0;
        if (!cx_end) begin
          cx <= cx + 1'b1;
        end else begin
          cx <= '0;
          if (!cy_end) begin
            cy <= cy + 1'b1;
          end else begin
            cy   <= '0;
            busy <= 1'b0;
          end
        end
      end
    end
  end

  // per-bank candidate addresses follow the row rotation
  for (genvar b = 0; b < LANES; b++) begin : g_caddr
    assign cand_addr[b*CAW +: CAW] =
      CAW'(bank_word(b, int'(cy), int'(cx), int'(hf), int'(col), LANES, AREA));
  end

  assign ref_addr = RAW'(int'(hf) * BLK + int'(col));

  // tags travel alongside the memory read latency
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_idx   <= '0;
      s1_rot   <= '0;
    end else begin
      s1_valid <= busy;
      s1_first <= busy && (col == '0) && (hf == '0);
      s1_last  <= busy && blk_last;
      s1_idx   <= IDXW'(int'(cy) * NPOS + int'(cx));
      s1_rot   <= ROTW'(cy);
    end
  end

endmodule

// File: rtl/sadm_lanes.sv
module sadm_lanes #(
  parameter int PIX_W = 8,
  parameter int LANES = 8,
  parameter int IDXW  = 7,
  parameter int ROTW  = 3,
  parameter int TW    = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*PIX_W-1:0]  cand_rdata,
  input  logic [LANES*PIX_W-1:0]  ref_rdata,
  input  logic                    s1_valid,
  input  logic                    s1_first,
  input  logic                    s1_last,
  input  logic [IDXW-1:0]         s1_idx,
  input  logic [ROTW-1:0]         s1_rot,
  output logic [TW-1:0]           tsum,
  output logic                    s2_valid,
  output logic                    s2_first,
  output logic                    s2_last,
  output logic [IDXW-1:0]         s2_idx
);
  import sadm_pkg::*;

  localparam int NODES = 2 * LANES - 1;

  logic [PIX_W-1:0] cpix [LANES];
  logic [PIX_W-1:0] rpix [LANES];
  logic [PIX_W-1:0] ad   [LANES];
  logic [TW-1:0]    node [NODES];

  // lane j pairs reference bank j with candidate bank (j + rot) mod LANES
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      int sel;
      sel     = (j + int'(s1_rot)) % LANES;
      cpix[j] = cand_rdata[sel*PIX_W +: PIX_W];
      rpix[j] = ref_rdata[j*PIX_W +: PIX_W];
      ad[j]   = PIX_W'(abs_diff(int'(cpix[j]), int'(rpix[j])));
    end
  end

  // binary reduction: LANES-1 adders, root at node 0
  always_comb begin
    for (int j = 0; j < LANES; j++) node[LANES-1+j] = TW'(ad[j]);
    for (int i = LANES - 2; i >= 0; i--) node[i] = node[2*i+1] + node[2*i+2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tsum     <= '0;
      s2_valid <= 1'b0;
      s2_first <= 1'b0;
      s2_last  <= 1'b0;
      s2_idx   <= '0;
    end else begin
      tsum     <= node[0];
      s2_valid <= s1_valid;
      s2_first <= s1_first;
      s2_last  <= s1_last;
      s2_idx   <= s1_idx;
    end
  end

endmodule

// File: rtl/sadm_acc.sv
module sadm_acc #(
  parameter int TW    = 11,
  parameter int SADW  = 16,
  parameter int IDXW  = 7,
  parameter int NCAND = 81
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TW-1:0]    tsum,
  input  logic             s2_valid,
  input  logic             s2_first,
  input  logic             s2_last,
  input  logic [IDXW-1:0]  s2_idx,
  output logic             res_we,
  output logic [IDXW-1:0]  res_addr,
  output logic [SADW-1:0]  res_wdata,
  output logic             done
);
  logic [SADW-1:0] acc;
  logic [SADW-1:0] sum_now;

  // first beat of a candidate restarts the running sum
  assign sum_now = (s2_first ? '0 : acc) + SADW'(tsum);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      res_we    <= 1'b0;
      res_addr  <= '0;
      res_wdata <= '0;
      done      <= 1'b0;
    end else begin
      if (s2_valid) acc <= sum_now;
      res_we <= s2_valid && s2_last;
      if (s2_valid && s2_last) begin
        res_addr  <= s2_idx;
        res_wdata <= sum_now;
      end
      done <= res_we && (res_addr == IDXW'(NCAND - 1));
    end
  end

endmodule

// File: rtl/sad_column_matcher.sv
module sad_column_matcher #(
  parameter int PIX_W = 8,
  parameter int LANES = 8,
  parameter int BLK   = 16,
  parameter int AREA  = 24,
  localparam int NPOS  = AREA - BLK + 1,
  localparam int NCAND = NPOS * NPOS,
  localparam int CROWS = AREA / LANES,
  localparam int CAW   = $clog2(CROWS * AREA),
  localparam int RAW   = $clog2((BLK / LANES) * BLK),
  localparam int IDXW  = $clog2(NCAND),
  localparam int SADW  = PIX_W + $clog2(BLK * BLK),
  localparam int ROTW  = $clog2(LANES),
  localparam int TW    = PIX_W + $clog2(LANES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  output logic [LANES*CAW-1:0]    cand_addr,
  input  logic [LANES*PIX_W-1:0]  cand_rdata,
  output logic [RAW-1:0]          ref_addr,
  input  logic [LANES*PIX_W-1:0]  ref_rdata,
  output logic                    res_we,
  output logic [IDXW-1:0]         res_addr,
  output logic [SADW-1:0]         res_wdata,
  output logic                    done
);

  logic            issue_v;
  logic            s1_valid, s1_first, s1_last;
  logic [IDXW-1:0] s1_idx;
  logic [ROTW-1:0] s1_rot;
  logic [TW-1:0]   tsum;
  logic            s2_valid, s2_first, s2_last;
  logic [IDXW-1:0] s2_idx;

  sadm_seq #(
    .LANES(LANES), .BLK(BLK), .AREA(AREA), .CAW(CAW), .RAW(RAW),
    .IDXW(IDXW), .ROTW(ROTW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .issue_v(issue_v),
    .cand_addr(cand_addr), .ref_addr(ref_addr),
    .s1_valid(s1_valid), .s1_first(s1_first), .s1_last(s1_last),
    .s1_idx(s1_idx), .s1_rot(s1_rot)
  );

  sadm_lanes #(
    .PIX_W(PIX_W), .LANES(LANES), .IDXW(IDXW), .ROTW(ROTW), .TW(TW)
  ) u_lanes (
    .clk(clk), .rst_n(rst_n), .cand_rdata(cand_rdata), .ref_rdata(ref_rdata),
    .s1_valid(s1_valid), .s1_first(s1_first), .s1_last(s1_last),
    .s1_idx(s1_idx), .s1_rot(s1_rot),
    .tsum(tsum), .s2_valid(s2_valid), .s2_first(s2_first),
    .s2_last(s2_last), .s2_idx(s2_idx)
  );

  sadm_acc #(
    .TW(TW), .SADW(SADW), .IDXW(IDXW), .NCAND(NCAND)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .tsum(tsum), .s2_valid(s2_valid),
    .s2_first(s2_first), .s2_last(s2_last), .s2_idx(s2_idx),
    .res_we(res_we), .res_addr(res_addr), .res_wdata(res_wdata), .done(done)
  );

endmodule

// File: rtl/sadm_chk.sv
module sadm_chk #(
  parameter int PIX_W = 8,
  parameter int LANES = 8,
  parameter int BLK   = 16,
  parameter int AREA  = 24,
  localparam int NPOS  = AREA - BLK + 1,
  localparam int NCAND = NPOS * NPOS,
  localparam int RAW   = $clog2((BLK / LANES) * BLK),
  localparam int IDXW  = $clog2(NCAND),
  localparam int SADW  = PIX_W + $clog2(BLK * BLK)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_v,
  input logic [RAW-1:0]  ref_addr,
  input logic            res_we,
  input logic [IDXW-1:0] res_addr,
  input logic [SADW-1:0] res_wdata,
  input logic            done
);
  localparam int SAD_MAX = BLK * BLK * ((1 << PIX_W) - 1);

  logic [IDXW-1:0] next_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) next_idx <= '0;
    else if (res_we) next_idx <= (res_addr == IDXW'(NCAND - 1)) ? '0 : res_addr + 1'b1;
  end

  p_raster_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> res_addr == next_idx);

  p_write_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> !res_we);

  p_done_follows_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(res_we) && $past(res_addr) == IDXW'(NCAND - 1)));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_half_pairing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_v && ref_addr < RAW'(BLK)) |=> (ref_addr == $past(ref_addr) + RAW'(BLK)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |-> int'(res_wdata) <= SAD_MAX);

endmodule

bind sad_column_matcher sadm_chk #(
  .PIX_W(PIX_W), .LANES(LANES), .BLK(BLK), .AREA(AREA)
) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_v(issue_v), .ref_addr(ref_addr),
  .res_we(res_we), .res_addr(res_addr), .res_wdata(res_wdata), .done(done)
);

// File: tb/tb_sad_column_matcher.sv
`timescale 1ns/1ps
module tb_sad_column_matcher;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [55:0] cand_addr;
  logic [63:0] cand_rdata = '0;
  logic [4:0]  ref_addr;
  logic [63:0] ref_rdata = '0;
  logic        res_we;
  logic [6:0]  res_addr;
  logic [15:0] res_wdata;
  logic        done;

  int vecs = 0;
  int errs = 0;
  bit finished = 1'b0;

  int cimg [24][24];
  int rimg [16][16];

  always #2.5 clk = ~clk;

  sad_column_matcher dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cand_addr(cand_addr), .cand_rdata(cand_rdata),
    .ref_addr(ref_addr), .ref_rdata(ref_rdata),
    .res_we(res_we), .res_addr(res_addr), .res_wdata(res_wdata), .done(done)
  );

  // bank models per R7: row-interleaved storage, one-cycle read latency
  always @(posedge clk) begin
    for (int b = 0; b < 8; b++) begin
      int a, r, c, ra, rr, rc;
      a  = int'(cand_addr[b*7 +: 7]);
      r  = (a / 24) * 8 + b;
      c  = a % 24;
      cand_rdata[b*8 +: 8] <= (r < 24) ? 8'(cimg[r][c]) : 8'h00;
      ra = int'(ref_addr);
      rr = (ra / 16) * 8 + b;
      rc = ra % 16;
      ref_rdata[b*8 +: 8] <= (rr < 16) ? 8'(rimg[rr][rc]) : 8'h00;
    end
  end

  function automatic int ref_sad(input int k);
    int cy, cx, s;
    cy = k / 9;
    cx = k % 9;
    s  = 0;
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 16; x++)
        s += (rimg[y][x] > cimg[cy+y][cx+x]) ? rimg[y][x] - cimg[cy+y][cx+x]
                                             : cimg[cy+y][cx+x] - rimg[y][x];
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // 0 random, 1 saturating, 2 exact match at (3,5), 3 gradient
  task automatic fill(input int mode);
    for (int r = 0; r < 24; r++)
      for (int c = 0; c < 24; c++)
        cimg[r][c] = (mode == 1) ? 0 :
                     (mode == 3) ? (r * 11 + c * 7) % 256 : int'($urandom % 256);
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 16; x++)
        rimg[y][x] = (mode == 1) ? 255 :
                     (mode == 2) ? cimg[y+5][x+3] :
                     (mode == 3) ? (y * 3 + x * 13 + 40) % 256 : int'($urandom % 256);
  endtask

  task automatic run_scan(input string dtag, input bit poke);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);                       // edge 0
    for (int n = 0; n <= 2600; n++) begin
      bit ewe;
      @(negedge clk);
      if (n == 0) start = 1'b0;
      ewe = (n >= 34) && ((n - 34) % 32 == 0) && ((n - 34) / 32 < 81);
      chk("R4 write strobe", int'(res_we), int'(ewe));
      if (ewe) begin
        chk("R3 result index", int'(res_addr), (n - 34) / 32);
        chk({dtag, " sad value"}, int'(res_wdata), ref_sad((n - 34) / 32));
      end
      chk("R5 done pulse", int'(done), int'(n == 2595));
      if (n < 2592) chk("R8 reference address", int'(ref_addr), 16 * (n % 2) + (n / 2) % 16);
      if (poke && (n == 700 || n == 1900)) start = 1'b1;   // R6: start mid-scan
      if (poke && (n == 701 || n == 1901)) start = 1'b0;
      @(posedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    fill(0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 res_we in reset", int'(res_we), 0);
      chk("R1 done in reset", int'(done), 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1 res_we idle", int'(res_we), 0);
      chk("R1 done idle", int'(done), 0);
    end
    run_scan("R2/R7 random", 1'b0);
    fill(1);
    run_scan("R9 saturating", 1'b0);
    chk("R9 max sum reference", ref_sad(40), 65280);
    fill(2);
    run_scan("R6 exact match", 1'b1);
    chk("R2 zero at match", ref_sad(48), 0);
    fill(3);
    run_scan("R10 restart gradient", 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R1 res_we after scans", int'(res_we), 0);
    end
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule